// File: doc/BRIEF.md
# Interpolating Pulse-Density Modulator

This block turns a stream of processed audio samples into a single-bit pulse-density output that can drive an electromagnetic transducer directly from a digital pin. Samples arrive with a one-cycle valid strobe at the audio rate. Each sample is first clamped to the modulator's full scale. A linear interpolator then doubles the rate: for each input it presents the midpoint between the previous and the new sample, and after that the new sample itself. A first-order error-feedback modulator, stepped by a fast clock enable, turns the resulting level into a bit stream whose local density of ones tracks the amplitude.

The level is offset to unsigned before modulation, so a zero level gives an even 50% ones density. The clamp limits are the exact points where the stream becomes all ones or all zeros, and the accumulator can never wrap. The parameter `HALF_LEN` gives the number of modulator enables in one half of an input period. With the default of 32, it fits a modulator enable at 64 times the 32 kHz input rate.

Top module: `pdm_interp_mod`

## Requirements
- R1: An input sample is clamped to the range -2^(DATA_W-1) to +2^(DATA_W-1) inclusive before it reaches the interpolator. A value outside that range is replaced by the nearer limit.
- R2: A valid strobe stores the clamped sample. From the next cycle, the modulator level is the midpoint: the sum of the previously stored sample and the new one, shifted right arithmetically by one bit, which rounds toward minus infinity.
- R3: Once the midpoint half ends, the level equals the newly stored sample. It keeps that value until the next valid strobe.
- R4: The midpoint level is in force for exactly HALF_LEN modulator enables after the valid cycle. When the valid strobe and an enable fall on the same edge, that enable uses the level that applied before the strobe.
- R5: On each enable, the modulator adds (level + 2^(DATA_W-1)) to an accumulator that holds values in the range [0, 2^DATA_W). When the sum is 2^DATA_W or more, the registered output becomes 1 and 2^DATA_W is subtracted. Otherwise the output becomes 0. The output changes on the clock edge of the enable.
- R6: While mod_en is low, the output and the accumulator hold their values.
- R7: A level of zero, starting from a cleared accumulator, gives the alternating pattern 0,1,0,1 on successive enables.
- R8: A level of +2^(DATA_W-1) gives 1 on every enable. A level of -2^(DATA_W-1) gives 0 on every enable. Leaving either extreme resumes normal modulation with no wrap effect.
- R9: Reset clears the accumulator and both stored samples and drives pdm_out to 0. Until the first valid strobe, the level is zero, so the output runs the 50% pattern of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe: a new input sample is present |
| smp_data | input | IN_W | Signed input sample, two's complement |
| mod_en | input | 1 | Fast modulator step enable |
| pdm_out | output | 1 | Pulse-density output bit |

## Verification
The assertions assume that a valid strobe is a single-cycle pulse. They also assume that strobes are spaced by at least HALF_LEN enables, so that the midpoint half always completes, and that mod_en is a plain enable with no relation to the strobe other than that spacing. The stimulus drives one strobe every 2*HALF_LEN cycles with the enable held high, or it holds the enable low for whole stretches. The samples cover in-range values, odd sums that exercise the floor rounding, and values far beyond both clamp limits.

// File: rtl/pdm_pkg.sv
`timescale 1ns/1ps
package pdm_pkg;
    // Which interpolated value drives the modulator.
    typedef enum logic {
        HALF_MID = 1'b0,
        HALF_CUR = 1'b1
    } half_e;
endpackage

// File: rtl/pdm_clamp.sv
`timescale 1ns/1ps
module pdm_clamp #(
    parameter int IN_W   = 18,
    parameter int DATA_W = 16
) (
    input  logic signed [IN_W-1:0] din,
    output logic signed [DATA_W:0] dout
);
    localparam logic signed [IN_W-1:0] LIM_HI = IN_W'(2 ** (DATA_W - 1));
    localparam logic signed [IN_W-1:0] LIM_LO = -LIM_HI;

    always_comb begin
        if (din > LIM_HI) begin
            dout = LIM_HI[DATA_W:0];
        end else if (din < LIM_LO) begin
            dout = LIM_LO[DATA_W:0];
        end else begin
            dout = din[DATA_W:0];
        end
    end
endmodule

// File: rtl/pdm_interp.sv
`timescale 1ns/1ps
module pdm_interp #(
    parameter int DATA_W   = 16,
    parameter int HALF_LEN = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_valid,
    input  logic signed [DATA_W:0] smp_in,
    input  logic                   mod_en,
    output logic signed [DATA_W:0] level,
    output pdm_pkg::half_e         half_sel
);
    localparam int CNT_W = $clog2(HALF_LEN + 1);

    typedef struct packed {
        logic signed [DATA_W:0] mid;
        logic signed [DATA_W:0] cur;
        logic [CNT_W-1:0]       cnt;
        pdm_pkg::half_e         half;
    } ip_state_t;

    ip_state_t st_d, st_q;
    logic signed [DATA_W+1:0] pair_sum;

    always_comb begin
        st_d     = st_q;
        pair_sum = {st_q.cur[DATA_W], st_q.cur} + {smp_in[DATA_W], smp_in};
        if (smp_valid) begin
            st_d.mid  = pair_sum[DATA_W+1:1];
            st_d.cur  = smp_in;
            st_d.cnt  = '0;
            st_d.half = pdm_pkg::HALF_MID;
        end else if (mod_en && st_q.half == pdm_pkg::HALF_MID) begin
            if (st_q.cnt == CNT_W'(HALF_LEN - 1)) begin
                st_d.cnt  = '0;
                st_d.half = pdm_pkg::HALF_CUR;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mid: '0, cur: '0, cnt: '0, half: pdm_pkg::HALF_CUR};
        end else begin
            st_q <= st_d;
        end
    end

    assign level    = (st_q.half == pdm_pkg::HALF_MID) ? st_q.mid : st_q.cur;
    assign half_sel = st_q.half;
endmodule

// File: rtl/pdm_sd.sv
`timescale 1ns/1ps
module pdm_sd #(
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mod_en,
    input  logic signed [DATA_W:0] level,
    output logic                   bit_out
);
    localparam logic [DATA_W:0] OFFSET = (DATA_W + 1)'(2 ** (DATA_W - 1));

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic              obit;
    } sd_state_t;

    sd_state_t sd_d, sd_q;
    logic [DATA_W:0] lvl_u;
    logic [DATA_W:0] acc_sum;

    always_comb begin
        sd_d    = sd_q;
        lvl_u   = $unsigned(level) + OFFSET;
        acc_sum = {1'b0, sd_q.acc} + lvl_u;
        if (mod_en) begin
            sd_d.acc  = acc_sum[DATA_W-1:0];
            sd_d.obit = acc_sum[DATA_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sd_q <= '0;
        end else begin
            sd_q <= sd_d;
        end
    end

    assign bit_out = sd_q.obit;
endmodule

// File: rtl/pdm_interp_mod.sv
`timescale 1ns/1ps
module pdm_interp_mod #(
    parameter int IN_W     = 18,
    parameter int DATA_W   = 16,
    parameter int HALF_LEN = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_valid,
    input  logic signed [IN_W-1:0] smp_data,
    input  logic                  mod_en,
    output logic                  pdm_out
);
    logic signed [DATA_W:0] smp_sat;
    logic signed [DATA_W:0] level_w;
    pdm_pkg::half_e         half_sel_w;

    pdm_clamp #(.IN_W(IN_W), .DATA_W(DATA_W)) u_clamp (
        .din  (smp_data),
        .dout (smp_sat)
    );

    pdm_interp #(.DATA_W(DATA_W), .HALF_LEN(HALF_LEN)) u_interp (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .smp_in   (smp_sat),
        .mod_en   (mod_en),
        .level    (level_w),
        .half_sel (half_sel_w)
    );

    pdm_sd #(.DATA_W(DATA_W)) u_sd (
        .clk    (clk),
        .rst_n  (rst_n),
        .mod_en (mod_en),
        .level  (level_w),
        .bit_out(pdm_out)
    );
endmodule

// File: rtl/pdm_interp_mod_chk.sv
`timescale 1ns/1ps
module pdm_interp_mod_chk #(
    parameter int DATA_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   smp_valid,
    input logic                   mod_en,
    input logic                   pdm_out,
    input logic signed [DATA_W:0] level,
    input pdm_pkg::half_e         half_sel
);
    localparam logic signed [DATA_W:0] LVL_MAX = (DATA_W + 1)'(2 ** (DATA_W - 1));
    localparam logic signed [DATA_W:0] LVL_MIN = -LVL_MAX;

    AST_LEVEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (level <= LVL_MAX) && (level >= LVL_MIN)); // R1

    AST_MID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> (half_sel == pdm_pkg::HALF_MID)); // R2

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> $stable(pdm_out)); // R6

    AST_SAT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && level == LVL_MAX) |=> pdm_out); // R8

    AST_SAT_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && level == LVL_MIN) |=> !pdm_out); // R8
endmodule

bind pdm_interp_mod pdm_interp_mod_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .mod_en   (mod_en),
    .pdm_out  (pdm_out),
    .level    (level_w),
    .half_sel (half_sel_w)
);

// File: tb/pdm_interp_mod_bench.sv
`timescale 1ns/1ps
module pdm_interp_mod_bench;
    localparam int IN_W     = 18;
    localparam int DATA_W   = 16;
    localparam int HALF_LEN = 4;
    localparam int FS       = 65536;
    localparam int HALF_FS  = 32768;
    localparam int NVEC     = 11;

    typedef struct packed {
        logic signed [IN_W-1:0] x;
        int                     mid;
        int                     cur;
    } vec_t;

    // input sample, expected midpoint level, expected second-half level
    localparam vec_t TBL [NVEC] = '{
        '{ 18'sd1000,        500,    1000},
        '{-18'sd3000,      -1000,   -3000},
        '{-18'sd3001,      -3001,   -3001},
        '{ 18'sd40000,     14883,   32768},
        '{ 18'sd32767,     32767,   32767},
        '{-18'sd70000,        -1,  -32768},
        '{-18'sd32768,    -32768,  -32768},
        '{ 18'sd0,        -16384,       0},
        '{ 18'sd131071,    16384,   32768},
        '{-18'sd131072,        0,  -32768},
        '{ 18'sd5,        -16382,       5}
    };

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   smp_valid = 1'b0;
    logic signed [IN_W-1:0] smp_data = '0;
    logic                   mod_en = 1'b0;
    logic                   pdm_out;

    int checks = 0;
    int errors = 0;
    int m_acc  = 0;
    logic m_bit = 1'b0;
    int mis    = 0;
    int ones   = 0;
    int ones_mid [NVEC];
    int ones_cur [NVEC];

    always #4 clk = ~clk;

    pdm_interp_mod #(.IN_W(IN_W), .DATA_W(DATA_W), .HALF_LEN(HALF_LEN)) u_pdm_interp_mod (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .mod_en   (mod_en),
        .pdm_out  (pdm_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Starts and ends at a falling edge; lvl is the level the requirements put in force at this edge.
    task automatic step(input logic v, input logic signed [IN_W-1:0] d, input logic en, input int lvl);
        int s;
        smp_valid = v;
        smp_data  = d;
        mod_en    = en;
        @(posedge clk);
        if (en) begin
            s     = m_acc + lvl + HALF_FS;
            m_bit = (s >= FS);
            m_acc = m_bit ? s - FS : s;
        end
        @(negedge clk);
        smp_valid = 1'b0;
        if (pdm_out !== m_bit) mis++;
        if (pdm_out === 1'b1) ones++;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        smp_valid = 1'b0;
        mod_en = 1'b0;
        m_acc = 0;
        m_bit = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int prev_cur;
        @(negedge clk);
        do_reset();
        // R9: output low after reset
        check(pdm_out === 1'b0, "R9 reset output", int'(pdm_out), 0);

        // R7 R9: no sample yet, level zero, alternating pattern 0,1,0,1
        mis = 0; ones = 0;
        step(1'b0, '0, 1'b1, 0);
        check(pdm_out === 1'b0, "R7 first bit", int'(pdm_out), 0);
        step(1'b0, '0, 1'b1, 0);
        check(pdm_out === 1'b1, "R7 second bit", int'(pdm_out), 1);
        step(1'b0, '0, 1'b1, 0);
        step(1'b0, '0, 1'b1, 0);
        check(mis == 0 && ones == 2, "R9 mid-scale pattern", ones, 2);

        // R6: enable low holds output and accumulator
        step(1'b0, '0, 1'b1, 0);          // bit 0, accumulator at half scale
        mis = 0; ones = 0;
        for (int k = 0; k < 5; k++) step(1'b0, 18'sd20000, 1'b0, 0);
        check(ones == 0, "R6 held output", ones, 0);
        step(1'b0, '0, 1'b1, 0);
        check(pdm_out === 1'b1 && mis == 0, "R6 accumulator held", int'(pdm_out), 1);

        // Table walk: one strobe every 2*HALF_LEN cycles, enable always high
        do_reset();
        prev_cur = 0;
        for (int i = 0; i < NVEC; i++) begin
            mis = 0;
            step(1'b1, TBL[i].x, 1'b1, prev_cur);   // R4: strobe edge still uses old level
            check(mis == 0, $sformatf("R4 strobe edge vec %0d", i), mis, 0);
            mis = 0; ones = 0;
            for (int k = 0; k < HALF_LEN; k++) step(1'b0, '0, 1'b1, TBL[i].mid);
            ones_mid[i] = ones;
            check(mis == 0, $sformatf("R2 R4 R5 midpoint half vec %0d", i), mis, 0);
            mis = 0; ones = 0;
            for (int k = 0; k < HALF_LEN - 1; k++) step(1'b0, '0, 1'b1, TBL[i].cur);
            ones_cur[i] = ones;
            check(mis == 0, $sformatf("R1 R3 R5 second half vec %0d", i), mis, 0);
            prev_cur = TBL[i].cur;
        end
        // R8: saturation at both extremes
        check(ones_mid[6] == 0 && ones_cur[6] == 0, "R8 all zeros at negative limit",
              ones_mid[6] + ones_cur[6], 0);
        check(ones_cur[8] == HALF_LEN - 1, "R8 all ones at positive limit",
              ones_cur[8], HALF_LEN - 1);
        check(ones_cur[3] == HALF_LEN - 1, "R1 clamped overrange gives all ones",
              ones_cur[3], HALF_LEN - 1);

        // R8: long positive saturation then zero, no wraparound
        do_reset();
        mis = 0; ones = 0;
        step(1'b1, 18'sd100000, 1'b1, 0);
        for (int k = 0; k < HALF_LEN; k++) step(1'b0, '0, 1'b1, 16384);
        ones = 0;
        for (int k = 0; k < 20; k++) step(1'b0, '0, 1'b1, HALF_FS);
        check(ones == 20 && mis == 0, "R8 sustained all ones", ones, 20);
        mis = 0;
        step(1'b1, 18'sd0, 1'b1, HALF_FS);
        for (int k = 0; k < HALF_LEN; k++) step(1'b0, '0, 1'b1, 16384);
        ones = 0;
        for (int k = 0; k < 8; k++) step(1'b0, '0, 1'b1, 0);
        check(ones == 4 && mis == 0, "R8 recovery to half density", ones, 4);

        finish_run();
    end
endmodule